// File: doc/BRIEF.md
# Dual Parallel Port with Direction Control

This block holds two byte-wide parallel ports, called A and B. Each port has its own direction register, in which a 1 marks a bit as an output. Software reaches the four registers through a synchronous byte bus with a 4-bit address. A byte written to a port is stored only in the bits configured as outputs. When a port is read back, the stored value shows on output bits and every input bit reads as 1.

An external agent, such as a pin sampler or a behavioural model of the board, can force single bits of either port register through a dedicated update channel per port. The block also tells a neighbouring interrupt unit when the per-port handshake flags must be dropped. It does this with a one-cycle clear mask that follows each ordinary port write.

Port A is also mapped at a second, quiet address. A write there stores data exactly like the ordinary address but leaves the handshake flags alone.

Top module: `dual_pport`

## Requirements
- R1: A synchronous active-high reset clears both port registers, both direction registers, the read data and the flag-clear mask to 0x00.
- R2: A bus write to offset 0x0 (port B) or 0x1 (port A) stores the written byte ANDed with that port's current direction register. The new value appears on the port data output one cycle later.
- R3: Direction registers live at offset 0x2 (port B) and 0x3 (port A). They take the written byte unmasked and read back exactly as written.
- R4: A read strobe latches the addressed register into the read data, which is valid the cycle after the strobe and holds while no read is made. A port reads as (data AND direction) OR (NOT direction), so every input bit reads as 1.
- R5: Offsets 0x4 through 0xE read as 0x00, and writes to them change no register and raise no flag clear.
- R6: A write to offset 0x0 drives the flag-clear mask to 0x18 (port B's two handshake flags) for exactly the next cycle.
- R7: A write to offset 0x1 drives the flag-clear mask to 0x03 (port A's two handshake flags) for exactly the next cycle.
- R8: A write to offset 0xF updates port A exactly like offset 0x1, but the flag-clear mask stays 0x00. A read of 0xF returns the same value as a read of 0x1.
- R9: A pin update sets or clears the single selected bit (index 0 to 7) of a port register regardless of that bit's direction. The change shows on the port data output one cycle later.
- R10: When a bus data write and a pin update hit the same port in one cycle, the bus write wins and the update is dropped. An update to the other port in that cycle still applies.
- R11: Reads never produce a flag-clear mask. The mask is 0x00 in any cycle that does not follow a port write at 0x0 or 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid one cycle after bus_rd |
| upd_a_en | input | 1 | Pin update strobe for port A |
| upd_a_idx | input | IDX_W | Bit index for port A update |
| upd_a_val | input | 1 | New value of the selected port A bit |
| upd_b_en | input | 1 | Pin update strobe for port B |
| upd_b_idx | input | IDX_W | Bit index for port B update |
| upd_b_val | input | 1 | New value of the selected port B bit |
| pa_data | output | DATA_W | Port A data register |
| pa_dir | output | DATA_W | Port A direction register (1 = output) |
| pb_data | output | DATA_W | Port B data register |
| pb_dir | output | DATA_W | Port B direction register (1 = output) |
| flag_clr | output | 8 | One-cycle handshake flag clear mask for the interrupt unit |

## Verification
All registers are brought straight to the ports, so a wrong data or direction bit shows up on pa_data, pb_data, pa_dir or pb_dir on the very edge it is stored. A bad read path shows up in bus_rdata one cycle after the read strobe. A decode fault shows the same way: a wrong flag-clear mask, or a missing or extra pulse, appears one cycle after the offending write. The bench keeps a behavioural model of all six visible registers and compares it on every clock, so any divergence is reported in the cycle it first appears rather than at a later read.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned NPORTS = 2;
  localparam int unsigned PORT_B = 0;
  localparam int unsigned PORT_A = 1;

  localparam logic [ADDR_W-1:0] OFS_PB       = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_PA       = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_DB       = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_DA       = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_PA_QUIET = 4'hF;

  localparam logic [FLAG_W-1:0] CLR_B_MASK = 8'h18;
  localparam logic [FLAG_W-1:0] CLR_A_MASK = 8'h03;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PB,
    SEL_PA,
    SEL_DB,
    SEL_DA
  } reg_sel_e;
endpackage

// File: rtl/dpp_addr_dec.sv
module dpp_addr_dec
  import dpp_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic [NPORTS-1:0] data_we,
  output logic [NPORTS-1:0] dir_we,
  output logic [FLAG_W-1:0] clr_mask
);
  always_comb begin
    sel      = SEL_NONE;
    data_we  = '0;
    dir_we   = '0;
    clr_mask = '0;
    unique case (addr)
      OFS_PB: begin
        sel = SEL_PB;
        data_we[PORT_B] = wr;
        clr_mask = wr ? CLR_B_MASK : '0;
      end
      OFS_PA: begin
        sel = SEL_PA;
        data_we[PORT_A] = wr;
        clr_mask = wr ? CLR_A_MASK : '0;
      end
      OFS_PA_QUIET: begin
        sel = SEL_PA;
        data_we[PORT_A] = wr;
      end
      OFS_DB: begin
        sel = SEL_DB;
        dir_we[PORT_B] = wr;
      end
      OFS_DA: begin
        sel = SEL_DA;
        dir_we[PORT_A] = wr;
      end
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dpp_port_reg.sv
module dpp_port_reg #(
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_we,
  input  logic              dir_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_val,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] view
);
  logic [DATA_W-1:0] upd_sel;

  always_comb begin
    upd_sel = '0;
    upd_sel[upd_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (data_we) data_q <= wdata & dir_q;
      else if (upd_en) data_q <= upd_val ? (data_q | upd_sel) : (data_q & ~upd_sel);
    end
  end

  assign view = (data_q & dir_q) | ~dir_q;
endmodule

// File: rtl/dpp_rd_mux.sv
module dpp_rd_mux
  import dpp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] view_a,
  input  logic [DATA_W-1:0] view_b,
  input  logic [DATA_W-1:0] dir_a,
  input  logic [DATA_W-1:0] dir_b,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    unique case (sel)
      SEL_PB:  rd_next = view_b;
      SEL_PA:  rd_next = view_a;
      SEL_DB:  rd_next = dir_b;
      SEL_DA:  rd_next = dir_a;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= rd_next;
  end
endmodule

// File: rtl/dpp_flag_pulse.sv
module dpp_flag_pulse #(
  parameter int unsigned FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] mask,
  output logic [FLAG_W-1:0] clr_q
);
  always_ff @(posedge clk) begin
    if (rst) clr_q <= '0;
    else     clr_q <= mask;
  end
endmodule

// File: rtl/dual_pport.sv
module dual_pport
  import dpp_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              upd_a_en,
  input  logic [IDX_W-1:0]  upd_a_idx,
  input  logic              upd_a_val,
  input  logic              upd_b_en,
  input  logic [IDX_W-1:0]  upd_b_idx,
  input  logic              upd_b_val,
  output logic [DATA_W-1:0] pa_data,
  output logic [DATA_W-1:0] pa_dir,
  output logic [DATA_W-1:0] pb_data,
  output logic [DATA_W-1:0] pb_dir,
  output logic [7:0]        flag_clr
);
  reg_sel_e          sel;
  logic [NPORTS-1:0] data_we, dir_we;
  logic [FLAG_W-1:0] clr_mask;

  logic [NPORTS-1:0]             upd_en_v;
  logic [NPORTS-1:0][IDX_W-1:0]  upd_idx_v;
  logic [NPORTS-1:0]             upd_val_v;
  logic [NPORTS-1:0][DATA_W-1:0] data_v, dir_v, view_v;

  assign upd_en_v[PORT_A]  = upd_a_en;
  assign upd_idx_v[PORT_A] = upd_a_idx;
  assign upd_val_v[PORT_A] = upd_a_val;
  assign upd_en_v[PORT_B]  = upd_b_en;
  assign upd_idx_v[PORT_B] = upd_b_idx;
  assign upd_val_v[PORT_B] = upd_b_val;

  dpp_addr_dec dec_i (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .sel      (sel),
    .data_we  (data_we),
    .dir_we   (dir_we),
    .clr_mask (clr_mask)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpp_port_reg #(.DATA_W(DATA_W)) port_i (
      .clk     (clk),
      .rst     (rst),
      .data_we (data_we[p]),
      .dir_we  (dir_we[p]),
      .wdata   (bus_wdata),
      .upd_en  (upd_en_v[p]),
      .upd_idx (upd_idx_v[p]),
      .upd_val (upd_val_v[p]),
      .data_q  (data_v[p]),
      .dir_q   (dir_v[p]),
      .view    (view_v[p])
    );
  end

  dpp_rd_mux #(.DATA_W(DATA_W)) rd_i (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .sel    (sel),
    .view_a (view_v[PORT_A]),
    .view_b (view_v[PORT_B]),
    .dir_a  (dir_v[PORT_A]),
    .dir_b  (dir_v[PORT_B]),
    .rdata  (bus_rdata)
  );

  dpp_flag_pulse #(.FLAG_W(FLAG_W)) flag_i (
    .clk   (clk),
    .rst   (rst),
    .mask  (clr_mask),
    .clr_q (flag_clr)
  );

  assign pa_data = data_v[PORT_A];
  assign pa_dir  = dir_v[PORT_A];
  assign pb_data = data_v[PORT_B];
  assign pb_dir  = dir_v[PORT_B];
endmodule

// File: rtl/dual_pport_chk.sv
module dual_pport_chk #(
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [3:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              upd_a_en,
  input logic [IDX_W-1:0]  upd_a_idx,
  input logic              upd_a_val,
  input logic [DATA_W-1:0] pa_data,
  input logic [DATA_W-1:0] pa_dir,
  input logic [DATA_W-1:0] pb_data,
  input logic [DATA_W-1:0] pb_dir,
  input logic [7:0]        flag_clr
);
  logic wr_a_any;
  assign wr_a_any = bus_wr && (bus_addr == 4'h1 || bus_addr == 4'hF);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pa_data == '0 && pb_data == '0 && pa_dir == '0 && pb_dir == '0 &&
             bus_rdata == '0 && flag_clr == 8'h00));

  assert_portb_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h0) |=> pb_data == ($past(bus_wdata) & $past(pb_dir)));

  assert_dira_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h3) |=> pa_dir == $past(bus_wdata));

  assert_porta_view_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 4'h1) |=>
      bus_rdata == (($past(pa_data) & $past(pa_dir)) | ~$past(pa_dir)));

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= 4'h4 && bus_addr <= 4'hE) |=> bus_rdata == '0);

  assert_clr_b_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h0) |=> flag_clr == 8'h18);

  assert_clr_a_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h1) |=> flag_clr == 8'h03);

  assert_quiet_alias_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'hF) |=>
      (flag_clr == 8'h00 && pa_data == ($past(bus_wdata) & $past(pa_dir))));

  assert_pin_update_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_a_en && !wr_a_any) |=> pa_data[$past(upd_a_idx)] == $past(upd_a_val));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (upd_a_en && wr_a_any) |=> pa_data == ($past(bus_wdata) & $past(pa_dir)));

  assert_no_clr_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> flag_clr == 8'h00);
endmodule

bind dual_pport dual_pport_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .upd_a_en  (upd_a_en),
  .upd_a_idx (upd_a_idx),
  .upd_a_val (upd_a_val),
  .pa_data   (pa_data),
  .pa_dir    (pa_dir),
  .pb_data   (pb_data),
  .pb_dir    (pb_dir),
  .flag_clr  (flag_clr)
);

// File: tb/dual_pport_tb_top.sv
module dual_pport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int IW = $clog2(W);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          upd_a_en = 1'b0, upd_a_val = 1'b0;
  logic          upd_b_en = 1'b0, upd_b_val = 1'b0;
  logic [IW-1:0] upd_a_idx = '0, upd_b_idx = '0;
  logic [W-1:0]  pa_data, pa_dir, pb_data, pb_dir;
  logic [7:0]    flag_clr;

  dual_pport #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_a_en(upd_a_en), .upd_a_idx(upd_a_idx), .upd_a_val(upd_a_val),
    .upd_b_en(upd_b_en), .upd_b_idx(upd_b_idx), .upd_b_val(upd_b_val),
    .pa_data(pa_data), .pa_dir(pa_dir), .pb_data(pb_data), .pb_dir(pb_dir),
    .flag_clr(flag_clr)
  );

  int n_chk = 0, n_err = 0;
  int m_pa = 0, m_pb = 0, m_da = 0, m_db = 0, m_rd = 0, m_clr = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int view(int d, int r);
    return ((d & r) | ~r) & 'hFF;
  endfunction

  function automatic int set_bit(int v, int idx, logic val);
    return val ? (v | (1 << idx)) : (v & ~(1 << idx));
  endfunction

  task automatic tick();
    int a;
    @(posedge clk);
    a = int'(bus_addr);
    if (rst) begin
      m_pa = 0; m_pb = 0; m_da = 0; m_db = 0; m_rd = 0; m_clr = 0;
    end else begin
      int n_pa, n_pb, n_da, n_db;
      bit wa, wb;
      n_pa = m_pa; n_pb = m_pb; n_da = m_da; n_db = m_db;
      if (bus_rd) begin
        case (a)
          0:       m_rd = view(m_pb, m_db);
          1, 15:   m_rd = view(m_pa, m_da);
          2:       m_rd = m_db;
          3:       m_rd = m_da;
          default: m_rd = 0;
        endcase
      end
      m_clr = !bus_wr ? 0 : (a == 0) ? 'h18 : (a == 1) ? 'h03 : 0;
      wa = bus_wr && (a == 1 || a == 15);
      wb = bus_wr && (a == 0);
      if (bus_wr && a == 2) n_db = int'(bus_wdata);
      if (bus_wr && a == 3) n_da = int'(bus_wdata);
      if (wa) n_pa = int'(bus_wdata) & m_da;
      else if (upd_a_en) n_pa = set_bit(m_pa, int'(upd_a_idx), upd_a_val);
      if (wb) n_pb = int'(bus_wdata) & m_db;
      else if (upd_b_en) n_pb = set_bit(m_pb, int'(upd_b_idx), upd_b_val);
      m_pa = n_pa; m_pb = n_pb; m_da = n_da; m_db = n_db;
    end
    #1;
    chk("R2 model pa_data", 32'(pa_data), 32'(m_pa));
    chk("R2 model pb_data", 32'(pb_data), 32'(m_pb));
    chk("R3 model pa_dir", 32'(pa_dir), 32'(m_da));
    chk("R3 model pb_dir", 32'(pb_dir), 32'(m_db));
    chk("R4 model bus_rdata", 32'(bus_rdata), 32'(m_rd));
    chk("R6 model flag_clr", 32'(flag_clr), 32'(m_clr));
  endtask

  task automatic bus(logic wr, logic rd, logic [3:0] addr, logic [W-1:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = d;
    tick();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; upd_a_en = 1'b0; upd_b_en = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    @(negedge clk); rst = 1'b0;
    chk("R1 pa_data", 32'(pa_data), 0);
    chk("R1 pb_dir", 32'(pb_dir), 0);
    chk("R1 rdata", 32'(bus_rdata), 0);
    chk("R1 flag_clr", 32'(flag_clr), 0);

    bus(1, 0, 4'h3, 8'hF0);
    chk("R3 dir A write", 32'(pa_dir), 32'h0F0);
    bus(1, 0, 4'h1, 8'hAB);
    chk("R2 port A masked", 32'(pa_data), 32'h0A0);
    chk("R7 clr after port A write", 32'(flag_clr), 32'h03);
    bus(0, 1, 4'h1, 8'h00);
    chk("R7 clr pulse one cycle", 32'(flag_clr), 0);
    chk("R4 port A read inputs high", 32'(bus_rdata), 32'h0AF);
    bus(0, 1, 4'h3, 8'h00);
    chk("R3 dir A readback", 32'(bus_rdata), 32'h0F0);
    chk("R11 read gives no clear", 32'(flag_clr), 0);

    bus(1, 0, 4'h2, 8'h0F);
    bus(1, 0, 4'h0, 8'h5C);
    chk("R2 port B masked", 32'(pb_data), 32'h00C);
    chk("R6 clr after port B write", 32'(flag_clr), 32'h18);
    bus(0, 1, 4'h0, 8'h00);
    chk("R4 port B read", 32'(bus_rdata), 32'h0FC);
    chk("R6 clr pulse one cycle", 32'(flag_clr), 0);

    bus(1, 0, 4'hF, 8'hFF);
    chk("R8 quiet alias data", 32'(pa_data), 32'h0F0);
    chk("R8 quiet alias no clear", 32'(flag_clr), 0);
    bus(0, 1, 4'hF, 8'h00);
    chk("R8 quiet alias read", 32'(bus_rdata), 32'h0FF);

    bus(1, 0, 4'h9, 8'hFF);
    chk("R5 unmapped write no clear", 32'(flag_clr), 0);
    chk("R5 unmapped write pa unchanged", 32'(pa_data), 32'h0F0);
    chk("R5 unmapped write pb dir unchanged", 32'(pb_dir), 32'h00F);
    bus(0, 1, 4'h7, 8'h00);
    chk("R5 unmapped read zero", 32'(bus_rdata), 0);

    @(negedge clk); upd_a_en = 1'b1; upd_a_idx = 3'd0; upd_a_val = 1'b1;
    bus(0, 0, 4'h0, 8'h00);
    chk("R9 set input bit", 32'(pa_data), 32'h0F1);
    @(negedge clk); upd_a_en = 1'b1; upd_a_idx = 3'd7; upd_a_val = 1'b0;
    bus(0, 0, 4'h0, 8'h00);
    chk("R9 clear output bit", 32'(pa_data), 32'h071);

    @(negedge clk);
    upd_a_en = 1'b1; upd_a_idx = 3'd4; upd_a_val = 1'b1;
    upd_b_en = 1'b1; upd_b_idx = 3'd1; upd_b_val = 1'b1;
    bus(1, 0, 4'h1, 8'h00);
    chk("R10 write beats update", 32'(pa_data), 0);
    chk("R10 other port update applies", 32'(pb_data), 32'h00E);

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      rst       = ($urandom_range(0, 99) == 0);
      bus_wr    = $urandom_range(0, 1) == 1;
      bus_rd    = $urandom_range(0, 1) == 1;
      bus_addr  = 4'($urandom_range(0, 15));
      bus_wdata = 8'($urandom);
      upd_a_en  = $urandom_range(0, 2) == 0;
      upd_a_idx = 3'($urandom);
      upd_a_val = 1'($urandom);
      upd_b_en  = $urandom_range(0, 2) == 0;
      upd_b_idx = 3'($urandom);
      upd_b_val = 1'($urandom);
      tick();
    end
    @(negedge clk);
    rst = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; upd_a_en = 1'b0; upd_b_en = 1'b0;
    tick();
    summary();
    $finish;
  end
endmodule